// File: doc/BRIEF.md
# Sextic Extension Field Cubing Unit

This unit computes the third power of an element of the degree-six extension of a ternary base field GF(3^M). The element is held in a tower basis: the base field is extended by a square root of minus one (σ, with σ² = −1), and that quadratic field is extended again by a cube root ρ that satisfies ρ³ = ρ + 1 for the "plus" curve or ρ³ = ρ − 1 for the "minus" curve. A one-bit curve select chooses between the two recombination patterns on every accepted input.

In characteristic three cubing is a linear map, so the whole cube is built from six base-field cubings that run side by side, each a fixed rewiring of trits followed by a trinomial reduction, plus a handful of trit-wise negations and additions. No multiplier is involved. One element can be accepted on every clock cycle; its cube appears on the output register one cycle later, marked by an output valid flag.

The base-field trinomial is x^M + MID_COEF·x^K + LOW_COEF and is set by parameters; the defaults select a 97-trit field.

Top module: `sextic_cube_unit`

## Requirements
- R1: Each trit is two bits with 00 = 0, 01 = 1, 10 = 2 (code 11 is never driven). A base-field element of M trits holds trit j (coefficient of x^j) at bits [2j+1:2j]. A 12M-bit word holds six base coefficients, coefficient i at bits [2M·i + 2M−1 : 2M·i], in the order 1, σ, ρ, σρ, ρ², σρ².
- R2: With curve_minus = 0 the output equals the input cubed under ρ³ = ρ + 1 and σ² = −1.
- R3: With curve_minus = 1 the output equals the input cubed under ρ³ = ρ − 1 and σ² = −1.
- R4: Base-field arithmetic is reduced by x^M + MID_COEF·x^K + LOW_COEF, so a single trit of weight x^j whose cube x^(3j) reaches degree M or higher is folded back into degree below M.
- R5: out_valid is high in exactly those cycles that follow a cycle with in_valid high; inputs are accepted on consecutive cycles without gaps.
- R6: When in_valid is low, out_elem keeps its previous value.
- R7: While rst_n is low out_valid is low, and it stays low until the first accepted input after release; inputs are accepted from the third rising edge after rst_n rises.
- R8: Every output trit carries one of the codes 00, 01, 10.
- R9: The cube of σ is −σ: an input of 1 in the σ coefficient gives 2 in the σ coefficient and zero elsewhere.
- R10: The cube of ρ is ρ + 1 on the plus curve and ρ − 1 (ρ + 2) on the minus curve.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input element present this cycle |
| curve_minus | input | 1 | 0 selects ρ³ = ρ + 1, 1 selects ρ³ = ρ − 1 |
| in_elem | input | 12M | Element to cube, layout per R1 |
| out_valid | output | 1 | out_elem holds a new cube |
| out_elem | output | 12M | Registered cube, layout per R1 |

## Verification
The bench runs a 5-trit field so that every single-trit input at every position of every coefficient can be swept for both curves; positions whose cube lands at degree M or more exercise the fold-back, and a wrong tap position or sign would show as misplaced trits there. The σ and ρ basis elements are checked against hand-written words, since a missing σ negation or a swapped curve sign would turn −σ into +σ or ρ − 1 into ρ + 1. Streams of random elements, back to back and with gaps, are compared with a reference that multiplies the element by itself twice, which catches a wrong recombination pattern, a dropped or duplicated valid, and an output register that reloads while idle.

// File: rtl/tcube_pkg.sv
package tcube_pkg;

  typedef logic [1:0] trit_t;

  function automatic trit_t t_add(trit_t a, trit_t b);
    logic [2:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= 3'd3) s = s - 3'd3;
    return s[1:0];
  endfunction

  function automatic trit_t t_neg(trit_t a);
    case (a)
      2'd1:    return 2'd2;
      2'd2:    return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  function automatic trit_t t_sub(trit_t a, trit_t b);
    return t_add(a, t_neg(b));
  endfunction

  function automatic trit_t t_scale(trit_t k, trit_t c);
    case (k)
      2'd1:    return c;
      2'd2:    return t_neg(c);
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/tcube_base_cube.sv
module tcube_base_cube
  import tcube_pkg::*;
#(
  parameter int M        = 97,
  parameter int K        = 16,
  parameter int MID_COEF = 1,
  parameter int LOW_COEF = 2
) (
  input  logic [2*M-1:0] a,
  output logic [2*M-1:0] y
);

  localparam int    WIDE  = 3*M - 2;
  localparam trit_t MID_T = trit_t'(MID_COEF);
  localparam trit_t LOW_T = trit_t'(LOW_COEF);

  trit_t wide [WIDE];

  // Frobenius spread (trit j -> degree 3j), then fold from the top degree down
  always_comb begin
    trit_t c;
    for (int d = 0; d < WIDE; d++) wide[d] = 2'd0;
    for (int j = 0; j < M; j++) wide[3*j] = a[2*j +: 2];
    for (int d = WIDE - 1; d >= M; d--) begin
      c = wide[d];
      wide[d] = 2'd0;
      wide[d - M + K] = t_sub(wide[d - M + K], t_scale(MID_T, c));
      wide[d - M]     = t_sub(wide[d - M],     t_scale(LOW_T, c));
    end
    for (int j = 0; j < M; j++) y[2*j +: 2] = wide[j];
  end

endmodule

// File: rtl/tcube_quad_cube.sv
module tcube_quad_cube
  import tcube_pkg::*;
#(
  parameter int M        = 97,
  parameter int K        = 16,
  parameter int MID_COEF = 1,
  parameter int LOW_COEF = 2
) (
  input  logic [4*M-1:0] a,
  output logic [4*M-1:0] y
);

  localparam int BW = 2*M;

  logic [BW-1:0] cubed [2];

  for (genvar h = 0; h < 2; h++) begin : g_half
    tcube_base_cube #(
      .M(M), .K(K), .MID_COEF(MID_COEF), .LOW_COEF(LOW_COEF)
    ) u_cube (
      .a(a[BW*h +: BW]),
      .y(cubed[h])
    );
  end

  // (a0 + a1 s)^3 = a0^3 - a1^3 s since s^3 = -s
  assign y[BW-1:0] = cubed[0];
  for (genvar j = 0; j < M; j++) begin : g_neg
    assign y[BW + 2*j +: 2] = t_neg(cubed[1][2*j +: 2]);
  end

endmodule

// File: rtl/tcube_recombine.sv
module tcube_recombine
  import tcube_pkg::*;
#(
  parameter int M = 97
) (
  input  logic           curve_minus,
  input  logic [4*M-1:0] q0,
  input  logic [4*M-1:0] q1,
  input  logic [4*M-1:0] q2,
  output logic [4*M-1:0] r0,
  output logic [4*M-1:0] r1,
  output logic [4*M-1:0] r2
);

  localparam int NT = 2*M;

  for (genvar t = 0; t < NT; t++) begin : g_trit
    trit_t a0, a1, a2, a1_sgn;
    assign a0     = q0[2*t +: 2];
    assign a1     = q1[2*t +: 2];
    assign a2     = q2[2*t +: 2];
    assign a1_sgn = curve_minus ? t_neg(a1) : a1;
    assign r0[2*t +: 2] = t_add(t_add(a0, a1_sgn), a2);
    assign r1[2*t +: 2] = curve_minus ? t_add(a1, a2) : t_sub(a1, a2);
    assign r2[2*t +: 2] = a2;
  end

endmodule

// File: rtl/sextic_cube_unit.sv
module sextic_cube_unit
  import tcube_pkg::*;
#(
  parameter int M        = 97,
  parameter int K        = 16,
  parameter int MID_COEF = 1,
  parameter int LOW_COEF = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            curve_minus,
  input  logic [12*M-1:0] in_elem,
  output logic            out_valid,
  output logic [12*M-1:0] out_elem
);

  localparam int QW = 4*M;
  localparam int EW = 12*M;

  // Reset release synchronizer
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // Quadratic-level cubes of the three rho coefficients
  logic [QW-1:0] qc [3];

  for (genvar i = 0; i < 3; i++) begin : g_quad
    tcube_quad_cube #(
      .M(M), .K(K), .MID_COEF(MID_COEF), .LOW_COEF(LOW_COEF)
    ) u_quad (
      .a(in_elem[QW*i +: QW]),
      .y(qc[i])
    );
  end

  logic [EW-1:0] cube_w;

  tcube_recombine #(.M(M)) u_recomb (
    .curve_minus(curve_minus),
    .q0(qc[0]),
    .q1(qc[1]),
    .q2(qc[2]),
    .r0(cube_w[0    +: QW]),
    .r1(cube_w[QW   +: QW]),
    .r2(cube_w[2*QW +: QW])
  );

  // Next state
  logic          valid_d, load_en;
  logic [EW-1:0] elem_d;

  always_comb begin
    valid_d = in_valid;
    load_en = in_valid;
    elem_d  = cube_w;
  end

  // Registers
  logic          valid_q;
  logic [EW-1:0] elem_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) valid_q <= 1'b0;
    else            valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (load_en) elem_q <= elem_d;
  end

  assign out_valid = valid_q;
  assign out_elem  = elem_q;

endmodule

// File: rtl/sextic_cube_unit_chk.sv
module sextic_cube_unit_chk #(
  parameter int M = 97
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [12*M-1:0] in_elem,
  input logic            out_valid,
  input logic [12*M-1:0] out_elem
);

  localparam logic [12*M-1:0] LOW_BITS = {6*M{2'b01}};

  logic seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seen_q <= 1'b0;
    else if (in_valid) seen_q <= 1'b1;
  end

  p_valid_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && !in_valid) |=> $stable(out_elem));

  p_legal_trits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (((out_elem >> 1) & out_elem & LOW_BITS) == '0));

  p_zero_maps_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_elem == '0) |=> (out_elem == '0));

endmodule

bind sextic_cube_unit sextic_cube_unit_chk #(.M(M)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .in_valid(in_valid),
  .in_elem(in_elem),
  .out_valid(out_valid),
  .out_elem(out_elem)
);

// File: tb/sextic_cube_unit_test.sv
`timescale 1ns/1ps
module sextic_cube_unit_test;

  localparam int TM   = 5;
  localparam int TK   = 2;
  localparam int TMID = 1;
  localparam int TLOW = 2;
  localparam int EW   = 12*TM;

  typedef int base_t [TM];
  typedef base_t ext_t [6];

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          curve_minus = 1'b0;
  logic [EW-1:0] in_elem = '0;
  logic          out_valid;
  logic [EW-1:0] out_elem;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sextic_cube_unit #(.M(TM), .K(TK), .MID_COEF(TMID), .LOW_COEF(TLOW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .curve_minus(curve_minus),
    .in_elem(in_elem), .out_valid(out_valid), .out_elem(out_elem)
  );

  // ---------------- reference arithmetic ----------------
  function automatic int md3(int v);
    return ((v % 3) + 3) % 3;
  endfunction

  function automatic base_t badd(base_t a, base_t b);
    base_t r;
    for (int i = 0; i < TM; i++) r[i] = md3(a[i] + b[i]);
    return r;
  endfunction

  function automatic base_t bsub(base_t a, base_t b);
    base_t r;
    for (int i = 0; i < TM; i++) r[i] = md3(a[i] - b[i]);
    return r;
  endfunction

  function automatic base_t bmul(base_t a, base_t b);
    int p [2*TM-1];
    base_t r;
    for (int i = 0; i < 2*TM-1; i++) p[i] = 0;
    for (int i = 0; i < TM; i++)
      for (int j = 0; j < TM; j++) p[i+j] += a[i] * b[j];
    for (int d = 2*TM-2; d >= TM; d--) begin
      int c;
      c = md3(p[d]);
      p[d] = 0;
      p[d-TM+TK] -= TMID * c;
      p[d-TM]    -= TLOW * c;
    end
    for (int i = 0; i < TM; i++) r[i] = md3(p[i]);
    return r;
  endfunction

  // full product in the sextic ring; minus selects rho^3 = rho - 1
  function automatic ext_t emul(ext_t a, ext_t b, bit minus);
    ext_t d [5];
    ext_t r;
    base_t z;
    for (int i = 0; i < TM; i++) z[i] = 0;
    for (int k = 0; k < 5; k++) begin
      d[k][0] = z; d[k][1] = z;
    end
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++) begin
        base_t re, im;
        re = bsub(bmul(a[2*i], b[2*j]), bmul(a[2*i+1], b[2*j+1]));
        im = badd(bmul(a[2*i], b[2*j+1]), bmul(a[2*i+1], b[2*j]));
        d[i+j][0] = badd(d[i+j][0], re);
        d[i+j][1] = badd(d[i+j][1], im);
      end
    for (int h = 0; h < 2; h++) begin
      // rho^4 = rho^2 +/- rho ; rho^3 = rho +/- 1
      d[2][h] = badd(d[2][h], d[4][h]);
      d[1][h] = minus ? bsub(d[1][h], d[4][h]) : badd(d[1][h], d[4][h]);
      d[1][h] = badd(d[1][h], d[3][h]);
      d[0][h] = minus ? bsub(d[0][h], d[3][h]) : badd(d[0][h], d[3][h]);
    end
    for (int k = 0; k < 3; k++) begin
      r[2*k] = d[k][0]; r[2*k+1] = d[k][1];
    end
    return r;
  endfunction

  function automatic logic [EW-1:0] pack(ext_t e);
    logic [EW-1:0] w;
    w = '0;
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < TM; j++) w[2*(TM*i+j) +: 2] = 2'(e[i][j]);
    return w;
  endfunction

  function automatic logic [EW-1:0] cube_ref(ext_t e, bit minus);
    return pack(emul(emul(e, e, minus), e, minus));
  endfunction

  function automatic ext_t zero_ext();
    ext_t e;
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < TM; j++) e[i][j] = 0;
    return e;
  endfunction

  // ---------------- checking ----------------
  task automatic check(string tag, logic [EW-1:0] act, logic [EW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  bit            pend_v = 0;
  logic [EW-1:0] pend_exp = '0;
  string         pend_tag = "";
  bit            have_out = 0;
  logic [EW-1:0] last_out = '0;

  task automatic cycle(bit v, bit minus, logic [EW-1:0] w, logic [EW-1:0] exp, string tag);
    @(negedge clk);
    check("R5 out_valid", EW'(out_valid), EW'(pend_v));
    if (pend_v) begin
      check(pend_tag, out_elem, pend_exp);
      check("R8 legal codes", EW'(((out_elem >> 1) & out_elem & {6*TM{2'b01}}) != '0), '0);
      last_out = out_elem;
      have_out = 1;
    end else if (have_out) begin
      check("R6 hold", out_elem, last_out);
    end
    in_valid    = v;
    curve_minus = minus;
    in_elem     = w;
    pend_v      = v;
    pend_exp    = exp;
    pend_tag    = tag;
  endtask

  task automatic send(ext_t e, bit minus, string tag);
    cycle(1'b1, minus, pack(e), cube_ref(e, minus), tag);
  endtask

  task automatic idle(logic [EW-1:0] junk);
    cycle(1'b0, 1'b0, junk, '0, "");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    ext_t e;
    // R7: reset state
    repeat (3) @(negedge clk);
    check("R7 out_valid in reset", EW'(out_valid), '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 out_valid after release", EW'(out_valid), '0);

    // R1 / R9 / R10: hand-written basis cubes
    cycle(1'b1, 1'b0, EW'(2'b01) << (2*TM*1), EW'(2'b10) << (2*TM*1), "R9 sigma cubed");
    cycle(1'b1, 1'b1, EW'(2'b01) << (2*TM*1), EW'(2'b10) << (2*TM*1), "R9 sigma cubed minus");
    cycle(1'b1, 1'b0, EW'(2'b01) << (2*TM*2),
          (EW'(2'b01) << (2*TM*2)) | EW'(2'b01), "R10 R1 rho plus");
    cycle(1'b1, 1'b1, EW'(2'b01) << (2*TM*2),
          (EW'(2'b01) << (2*TM*2)) | EW'(2'b10), "R10 R1 rho minus");
    idle('1);
    idle('0);

    // R4: every single trit, every position, both values, both curves
    for (int cv = 0; cv < 2; cv++)
      for (int ci = 0; ci < 6; ci++)
        for (int tj = 0; tj < TM; tj++)
          for (int val = 1; val < 3; val++) begin
            e = zero_ext();
            e[ci][tj] = val;
            send(e, bit'(cv), "R4 single trit");
          end
    idle('0);

    // R2 / R3: random streams, back to back with occasional gaps (R6)
    for (int n = 0; n < 3000; n++) begin
      bit minus;
      e = zero_ext();
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < TM; j++) e[i][j] = int'($urandom % 3);
      minus = bit'($urandom % 2);
      send(e, minus, minus ? "R3 random minus" : "R2 random plus");
      if ($urandom % 8 == 0) idle(EW'({$urandom, $urandom}));
    end
    idle('0);
    idle('0);

    // R7: reset mid-stream
    @(negedge clk);
    in_valid = 1'b1;
    in_elem  = '0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R7 out_valid cleared by reset", EW'(out_valid), '0);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 out_valid held in reset", EW'(out_valid), '0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule